// File: doc/BRIEF.md
# Dual-Mode Caller Identity Serial Port

This block carries caller-identity bytes from an asynchronous 1200-baud receiver to a host controller. It uses three wires: a data line, a data clock and an active-low data-ready strobe. The receiver hands over one bit per strobe, and the stream includes start and stop framing. An internal framer looks for a start bit, gathers eight data bits least significant first, and then checks the stop bit.

A mode select input sets who owns the data clock. With the select low (push mode), the block drives the clock itself. Each data bit goes out on the data line as soon as it is recovered, and one clock pulse follows it. After the eighth pulse of a word, data-ready pulses low to mark the byte boundary. With the select high (pull mode), the clock pin is an input driven by the host. A correctly framed byte is held in a one-byte buffer, and data-ready stays low while that byte waits to be read. The host then steps through the bits with rising clock edges, which are synchronised to the system clock. A byte that completes while the buffer still holds an unread byte raises a sticky overrun flag, and the buffered byte is kept.

Top module: `cid_serial_if`

## Requirements
- R1: With `mode_sel` low, `dclk_oe` is 1 and the block drives `dclk_o`. With `mode_sel` high, `dclk_oe` is 0 and `dclk_o` stays 0.
- R2: Framing works as follows. While idle, received 1 bits are ignored. A received 0 starts a frame. The next 8 strobes are data bits, least significant first. The strobe after them is the stop bit. Start, stop and idle bits produce no clock pulse and no data-line change in push mode.
- R3: Push-mode data bits follow a fixed timing. In the cycle after a data bit's strobe, `data_o` equals that bit and `dclk_o` is 0. `dclk_o` is then 1 for exactly PULSE_W (default 4) consecutive cycles.
- R4: In push mode, `dr_n_o` goes low in the cycle after the eighth data bit's clock pulse ends. It stays low for DR_W (default 6) cycles and is high at all other times.
- R5: In pull mode, a frame whose stop bit is 1 loads the buffer. `dr_n_o` is low within 2 cycles of the stop strobe, and `data_o` then shows data bit 0.
- R6: In pull mode with a byte waiting, each rising edge of `host_dclk_i` advances `data_o` to the next data bit. The change appears within 4 system cycles of the edge.
- R7: In pull mode, `dr_n_o` returns high after the eighth host rising edge, and not before.
- R8: In pull mode, a frame whose stop bit is 0 is discarded and `dr_n_o` stays high. The framer then accepts the next frame normally.
- R9: In pull mode, a byte completing while the buffer is full sets `overrun_o` to 1 until reset. The unread byte is kept unchanged.
- R10: In pull mode with an empty buffer, host clock edges have no effect: `dr_n_o` stays 1 and `data_o` stays 0.
- R11: After reset, `dr_n_o` is 1, and `data_o`, `dclk_o` and `overrun_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 1 | 0 = push mode (block drives clock), 1 = pull mode (host drives clock) |
| rx_bit | input | 1 | Received bit from the 1200-baud receiver |
| rx_vld | input | 1 | One-cycle strobe, one per received bit |
| host_dclk_i | input | 1 | Host-supplied data clock (pull mode) |
| dclk_o | output | 1 | Block-driven data clock (push mode) |
| dclk_oe | output | 1 | Output enable for the data clock pin |
| data_o | output | 1 | Serial data line |
| dr_n_o | output | 1 | Active-low data-ready |
| overrun_o | output | 1 | Sticky pull-mode overrun flag |

## Verification
Every byte value from 0 to 255 is framed and sent in both modes. This sweep separates bit-order and bit-position faults: in push mode the byte is rebuilt from the data line at each pulse, and in pull mode it is rebuilt from host-clocked reads. Push mode also receives runs of idle 1 bits, and each start and stop bit is watched. This shows that framing bits never produce a clock pulse, and that the data-ready pulse follows only the eighth data bit. Pull mode is also given a frame with a bad stop bit, host clock edges with no byte waiting, and a second byte sent before the first is read. These cases separate discard behaviour from buffer loading, and overrun from overwrite.

// File: rtl/cid_pkg.sv
package cid_pkg;
  typedef enum logic [1:0] {
    FR_IDLE = 2'd0,
    FR_DATA = 2'd1,
    FR_STOP = 2'd2
  } fr_state_e;
endpackage

// File: rtl/cid_framer.sv
module cid_framer
  import cid_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_bit,
  input  logic              rx_vld,
  output logic              bit_stb,
  output logic              bit_last,
  output logic              byte_vld,
  output logic [DATA_W-1:0] byte_o
);
  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(DATA_W - 1);

  fr_state_e         st_q, st_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [DATA_W-1:0] sh_q, sh_d;
  logic              bv_q, bv_d;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    sh_d  = sh_q;
    bv_d  = 1'b0;
    if (rx_vld) begin
      case (st_q)
        FR_IDLE: if (!rx_bit) begin
          st_d  = FR_DATA;
          cnt_d = '0;
        end
        FR_DATA: begin
          sh_d  = {rx_bit, sh_q[DATA_W-1:1]};
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == LAST_IDX) st_d = FR_STOP;
        end
        default: begin
          st_d = FR_IDLE;
          bv_d = rx_bit;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= FR_IDLE;
      cnt_q <= '0;
      sh_q  <= '0;
      bv_q  <= 1'b0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      sh_q  <= sh_d;
      bv_q  <= bv_d;
    end
  end

  assign bit_stb  = rx_vld && (st_q == FR_DATA);
  assign bit_last = (cnt_q == LAST_IDX);
  assign byte_vld = bv_q;
  assign byte_o   = sh_q;

  // R2: a byte is only declared after a stop strobe carrying a 1
  assert_byte_on_stop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld |-> $past(rx_vld && rx_bit));
endmodule

// File: rtl/cid_push_tx.sv
module cid_push_tx #(
  parameter int PULSE_W = 4,
  parameter int DR_W    = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic bit_stb,
  input  logic bit_last,
  input  logic rx_bit,
  output logic data_o,
  output logic dclk_o,
  output logic dr_act
);
  localparam int PC_W = $clog2(PULSE_W + 2);
  localparam int DC_W = $clog2(DR_W + 1);
  localparam logic [PC_W-1:0] PC_LOAD = PC_W'(PULSE_W + 1);
  localparam logic [PC_W-1:0] PC_HI   = PC_W'(PULSE_W);
  localparam logic [DC_W-1:0] DC_LOAD = DC_W'(DR_W);

  logic [PC_W-1:0] pc_q, pc_d;
  logic [DC_W-1:0] dc_q, dc_d;
  logic            last_q, last_d;
  logic            dat_q, dat_d;

  always_comb begin
    pc_d   = pc_q;
    dc_d   = dc_q;
    last_d = last_q;
    dat_d  = dat_q;
    if (dc_q != '0) dc_d = dc_q - 1'b1;
    if (en && bit_stb) begin
      dat_d  = rx_bit;
      pc_d   = PC_LOAD;
      last_d = bit_last;
    end else if (pc_q != '0) begin
      pc_d = pc_q - 1'b1;
      if (pc_q == PC_W'(1) && last_q) begin
        dc_d   = DC_LOAD;
        last_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q   <= '0;
      dc_q   <= '0;
      last_q <= 1'b0;
      dat_q  <= 1'b0;
    end else begin
      pc_q   <= pc_d;
      dc_q   <= dc_d;
      last_q <= last_d;
      dat_q  <= dat_d;
    end
  end

  assign dclk_o = (pc_q != '0) && (pc_q <= PC_HI);
  assign dr_act = (dc_q != '0);
  assign data_o = dat_q;

  // R4: the data-ready window opens only right after a clock pulse ends
  assert_dr_after_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dr_act) |-> $past(dclk_o));
endmodule

// File: rtl/cid_pull_buf.sv
module cid_pull_buf #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              host_clk,
  input  logic              byte_vld,
  input  logic [DATA_W-1:0] byte_i,
  output logic              data_o,
  output logic              full_o,
  output logic              ovr_o
);
  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(DATA_W - 1);

  logic              s1_q, s2_q, s3_q, rise;
  logic [DATA_W-1:0] sh_q, sh_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              full_q, full_d;
  logic              ovr_q, ovr_d;

  assign rise = s2_q & ~s3_q;

  always_comb begin
    sh_d   = sh_q;
    cnt_d  = cnt_q;
    full_d = full_q;
    ovr_d  = ovr_q;
    if (full_q && rise) begin
      sh_d  = {1'b0, sh_q[DATA_W-1:1]};
      cnt_d = cnt_q + 1'b1;
      if (cnt_q == LAST_IDX) begin
        full_d = 1'b0;
        cnt_d  = '0;
      end
    end
    if (en && byte_vld) begin
      if (full_q) begin
        ovr_d = 1'b1;
      end else begin
        sh_d   = byte_i;
        full_d = 1'b1;
        cnt_d  = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= 1'b0;
      s2_q   <= 1'b0;
      s3_q   <= 1'b0;
      sh_q   <= '0;
      cnt_q  <= '0;
      full_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      s1_q   <= host_clk;
      s2_q   <= s1_q;
      s3_q   <= s2_q;
      sh_q   <= sh_d;
      cnt_q  <= cnt_d;
      full_q <= full_d;
      ovr_q  <= ovr_d;
    end
  end

  assign data_o = sh_q[0];
  assign full_o = full_q;
  assign ovr_o  = ovr_q;

  // R7: the buffer empties only on a host rising edge
  assert_release_on_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(full_q) |-> $past(rise));
  // R9: a byte arriving while full flags overrun and leaves the buffer alone
  assert_overrun_keeps_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (full_q && en && byte_vld && !rise) |=> (ovr_q && $stable(sh_q)));
  // R10: host edges on an empty buffer change nothing
  assert_empty_edge_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!full_q && rise && !(en && byte_vld)) |=> ($stable(sh_q) && !full_q));
endmodule

// File: rtl/cid_serial_if.sv
module cid_serial_if #(
  parameter int DATA_W  = 8,
  parameter int PULSE_W = 4,
  parameter int DR_W    = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mode_sel,
  input  logic rx_bit,
  input  logic rx_vld,
  input  logic host_dclk_i,
  output logic dclk_o,
  output logic dclk_oe,
  output logic data_o,
  output logic dr_n_o,
  output logic overrun_o
);
  logic              rs1_q, rs2_q;
  logic              bit_stb, bit_last, byte_vld;
  logic [DATA_W-1:0] byte_w;
  logic              push_dat, push_clk, push_dr;
  logic              pull_dat, pull_full, pull_ovr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q <= 1'b0;
      rs2_q <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rs2_q <= rs1_q;
    end
  end

  cid_framer #(.DATA_W(DATA_W)) u_framer (
    .clk(clk), .rst_n(rs2_q), .rx_bit(rx_bit), .rx_vld(rx_vld),
    .bit_stb(bit_stb), .bit_last(bit_last), .byte_vld(byte_vld), .byte_o(byte_w)
  );

  cid_push_tx #(.PULSE_W(PULSE_W), .DR_W(DR_W)) u_push (
    .clk(clk), .rst_n(rs2_q), .en(~mode_sel), .bit_stb(bit_stb),
    .bit_last(bit_last), .rx_bit(rx_bit), .data_o(push_dat),
    .dclk_o(push_clk), .dr_act(push_dr)
  );

  cid_pull_buf #(.DATA_W(DATA_W)) u_pull (
    .clk(clk), .rst_n(rs2_q), .en(mode_sel), .host_clk(host_dclk_i),
    .byte_vld(byte_vld), .byte_i(byte_w), .data_o(pull_dat),
    .full_o(pull_full), .ovr_o(pull_ovr)
  );

  assign dclk_oe   = ~mode_sel;
  assign dclk_o    = push_clk & ~mode_sel;
  assign data_o    = mode_sel ? pull_dat : push_dat;
  assign dr_n_o    = mode_sel ? ~pull_full : ~push_dr;
  assign overrun_o = pull_ovr;

  // R1: in pull mode the block never drives a clock edge
  assert_no_drive_pull_R1: assert property (@(posedge clk) disable iff (!rs2_q)
    mode_sel |-> (!dclk_o && !dclk_oe));
endmodule

// File: tb/cid_serial_if_tb_top.sv
module cid_serial_if_tb_top;
  localparam int PW = 4;
  localparam int DW = 6;

  logic clk = 1'b0;
  logic rst_n, mode_sel, rx_bit, rx_vld, host_dclk_i;
  logic dclk_o, dclk_oe, data_o, dr_n_o, overrun_o;
  int   n_cmp = 0;
  int   n_bad = 0;

  always #4 clk = ~clk;

  cid_serial_if #(.DATA_W(8), .PULSE_W(PW), .DR_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .rx_bit(rx_bit),
    .rx_vld(rx_vld), .host_dclk_i(host_dclk_i), .dclk_o(dclk_o),
    .dclk_oe(dclk_oe), .data_o(data_o), .dr_n_o(dr_n_o), .overrun_o(overrun_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; rx_vld = 1'b0; rx_bit = 1'b1; host_dclk_i = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  task automatic send_bit(input logic b, input int gap);
    @(negedge clk); rx_bit = b; rx_vld = 1'b1;
    @(negedge clk); rx_vld = 1'b0; rx_bit = 1'b1;
    repeat (gap) @(negedge clk);
  endtask

  // push mode: send one bit, watch 12 cycles; returns data, pulse and dr counts
  task automatic push_bit(input logic b, output int d, output int ck0,
                          output int nclk, output int ndr);
    @(negedge clk); rx_bit = b; rx_vld = 1'b1;
    @(negedge clk); rx_vld = 1'b0; rx_bit = 1'b1;
    d = int'(data_o); ck0 = int'(dclk_o); nclk = 0; ndr = 0;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      if (dclk_o) nclk++;
      if (!dr_n_o) ndr++;
    end
  endtask

  task automatic send_frame(input logic [7:0] v, input logic stop);
    send_bit(1'b0, 2);
    for (int i = 0; i < 8; i++) send_bit(v[i], 2);
    send_bit(stop, 2);
  endtask

  task automatic host_read(output logic [7:0] v, output int dr_before_last);
    dr_before_last = 1;
    for (int i = 0; i < 8; i++) begin
      v[i] = data_o;
      if (i == 7) dr_before_last = int'(dr_n_o);
      host_dclk_i = 1'b1; repeat (6) @(negedge clk);
      host_dclk_i = 1'b0; repeat (6) @(negedge clk);
    end
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : main
    int d, ck0, nc, nd, drl, bad_push;
    logic [7:0] got;
    mode_sel = 1'b0;
    do_reset();
    // R11 reset state
    chk("R11 dr_n", int'(dr_n_o), 1);
    chk("R11 data", int'(data_o), 0);
    chk("R11 dclk", int'(dclk_o), 0);
    chk("R11 ovr", int'(overrun_o), 0);
    chk("R1 oe push", int'(dclk_oe), 1);

    // R2 idle ones produce nothing in push mode
    for (int k = 0; k < 5; k++) begin
      push_bit(1'b1, d, ck0, nc, nd);
      chk("R2 idle clk", nc, 0);
      chk("R2 idle dr", nd, 0);
    end

    // push mode sweep over all byte values
    for (int v = 0; v < 256; v++) begin
      bad_push = 0;
      push_bit(1'b0, d, ck0, nc, nd);
      chk("R2 start clk", nc + nd, 0);
      for (int i = 0; i < 8; i++) begin
        push_bit(v[i], d, ck0, nc, nd);
        got[i] = d[0];
        if (ck0 != 0) bad_push++;
        chk("R3 pulse width", nc, PW);
        chk("R4 dr window", nd, (i == 7) ? DW : 0);
      end
      chk("R3 byte lsb-first", int'(got), v);
      chk("R3 setup low", bad_push, 0);
      push_bit(1'b1, d, ck0, nc, nd);
      chk("R2 stop clk", nc + nd, 0);
      chk("R2 stop data", d, v[7]);
    end

    // pull mode
    mode_sel = 1'b1;
    @(negedge clk);
    chk("R1 oe pull", int'(dclk_oe), 0);
    chk("R1 dclk pull", int'(dclk_o), 0);
    // R10 host edges on empty buffer
    for (int k = 0; k < 3; k++) begin
      host_dclk_i = 1'b1; repeat (6) @(negedge clk);
      host_dclk_i = 1'b0; repeat (6) @(negedge clk);
    end
    chk("R10 dr_n", int'(dr_n_o), 1);
    chk("R10 data", int'(data_o), 0);

    for (int v = 0; v < 256; v++) begin
      send_frame(v[7:0], 1'b1);
      chk("R5 dr_n low", int'(dr_n_o), 0);
      chk("R5 bit0", int'(data_o), v & 1);
      host_read(got, drl);
      chk("R6 byte", int'(got), v);
      chk("R7 held to last", drl, 0);
      chk("R7 released", int'(dr_n_o), 1);
    end
    chk("R9 no ovr", int'(overrun_o), 0);

    // R8 bad stop bit discarded, next frame fine
    send_frame(8'h5A, 1'b0);
    repeat (4) @(negedge clk);
    chk("R8 discarded", int'(dr_n_o), 1);
    send_frame(8'hC3, 1'b1);
    chk("R8 recover dr", int'(dr_n_o), 0);
    host_read(got, drl);
    chk("R8 recover byte", int'(got), 8'hC3);

    // R9 overrun keeps old byte
    send_frame(8'hA5, 1'b1);
    chk("R9 pre ovr", int'(overrun_o), 0);
    send_frame(8'h3C, 1'b1);
    chk("R9 ovr set", int'(overrun_o), 1);
    host_read(got, drl);
    chk("R9 old kept", int'(got), 8'hA5);
    chk("R9 empty after", int'(dr_n_o), 1);
    repeat (10) @(negedge clk);
    chk("R9 sticky", int'(overrun_o), 1);
    do_reset();
    chk("R11 ovr cleared", int'(overrun_o), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule